// File: doc/BRIEF.md
# Thread Resume-Address Queue with Head-Line Prefetch

This block holds the resumption points of the cooperative threads that are still active in a tick-based runtime. When a thread reaches its end-of-tick point, command logic loads its resume address together with a scheduling priority. The block keeps the entries sorted so that the thread which runs next is always at the head.

While the current thread executes, the block fetches the instruction line that holds the head entry's resume address from memory. It stores that line in a one-line buffer. At a context switch the processor pops the head and takes the buffered line. The switch then costs the same as running into the next line of straight-line code. The block then starts a fetch for the new head.

The memory side is a simple request/acknowledge port. A request is held, with a stable aligned line address, until a one-cycle acknowledge arrives carrying the line.

Top module: `thrd_resume_q`

## Requirements
- R1: After reset, head_valid, buf_valid, mem_req and ovf_pulse are all 0.
- R2: The head entry is always the one with the numerically smallest ld_prio value, so priority 0 runs first.
- R3: Entries of equal priority leave the queue in the order in which they were loaded.
- R4: A load into a queue that already holds DEPTH entries, with no pop in the same cycle, is dropped. The queue contents are unchanged, and ovf_pulse is 1 for exactly the following cycle.
- R5: A pop while the queue is empty has no effect: head_valid stays 0 and no memory request is made.
- R6: In the cycle after the head entry changes, buf_valid is 0. The same cycle, mem_req is 1 with mem_addr equal to head_addr with its low log2(LINE_W/8) bits cleared. The request address is held until mem_ack.
- R7: buf_valid rises only on a mem_ack. While buf_valid is 1, buf_line is the memory data of the line that holds head_addr.
- R8: A pop with buf_valid high removes the head. The line on buf_line in the pop cycle belongs to the popped entry. In the next cycle, the second entry is the head.
- R9: If the head changes while a request is outstanding, the data returned for that request is discarded. A new request is then made for the new head's line.
- R10: A pop and a load in the same cycle on a full queue are both accepted. The load is placed among the remaining entries, and ovf_pulse stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load command strobe |
| ld_addr | input | ADDR_W | Resume address to enqueue |
| ld_prio | input | PRIO_W | Priority of the entry, smaller runs first |
| pop | input | 1 | Context switch: remove the head |
| head_valid | output | 1 | Queue is not empty |
| head_addr | output | ADDR_W | Resume address of the head entry |
| buf_valid | output | 1 | Buffered line belongs to the head |
| buf_line | output | LINE_W | Prefetched instruction line |
| ovf_pulse | output | 1 | A load was rejected in the previous cycle |
| mem_req | output | 1 | Line fetch request |
| mem_addr | output | ADDR_W | Line-aligned fetch address |
| mem_ack | input | 1 | Fetch complete, mem_data valid |
| mem_data | input | LINE_W | Fetched line |

## Verification
The hardest case to reach is a head change that lands while a fetch is still in flight. To reach it, the bench keeps memory latency at several cycles. It loads a low-urgency entry and, on the very next cycle, loads a more urgent one. This forces a discard of the first line and a second request. The bench counts acknowledges to prove that the refetch took place, and checks the buffered line against the new head's pattern. The simultaneous pop-and-load on a full queue is reached by filling the queue first and then driving both strobes in one cycle.

// File: rtl/thrq_pkg.sv
package thrq_pkg;
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_BUSY = 1'b1
   } fetch_st_t;
endpackage

// File: rtl/thrq_store.sv
module thrq_store #(
   parameter int ADDR_W = 16,
   parameter int PRIO_W = 3,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [PRIO_W-1:0] ld_prio,
   input  logic              pop,
   output logic [CNT_W-1:0]  occ,
   output logic              head_valid,
   output logic [ADDR_W-1:0] head_addr,
   output logic              hd_upd,
   output logic              nxt_valid,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic              ovf_pulse
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [ADDR_W-1:0] a_q [DEPTH];
   logic [PRIO_W-1:0] p_q [DEPTH];
   logic [ADDR_W-1:0] a_1 [DEPTH];
   logic [PRIO_W-1:0] p_1 [DEPTH];
   logic [ADDR_W-1:0] a_n [DEPTH];
   logic [PRIO_W-1:0] p_n [DEPTH];
   logic [CNT_W-1:0]  occ_q, c_1, c_n, pos;
   logic              pop_ok, ins_ok, ovf_q;

   // stage 1: remove the head when a pop is honoured
   assign pop_ok = pop && (occ_q != '0);
   assign c_1    = occ_q - CNT_W'(pop_ok);
   assign ins_ok = ld_valid && (c_1 != FULL);
   assign c_n    = c_1 + CNT_W'(ins_ok);

   // insertion point: after every surviving entry of equal or smaller priority
   always_comb begin
      pos = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if ((CNT_W'(i) < c_1) && (p_1[i] <= ld_prio)) pos = pos + CNT_W'(1);
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g == DEPTH - 1) begin : g_tail
         assign a_1[g] = pop_ok ? '0 : a_q[g];
         assign p_1[g] = pop_ok ? '0 : p_q[g];
      end else begin : g_body
         assign a_1[g] = pop_ok ? a_q[g+1] : a_q[g];
         assign p_1[g] = pop_ok ? p_q[g+1] : p_q[g];
      end
      if (g == 0) begin : g_head
         assign a_n[g] = (ins_ok && pos == '0) ? ld_addr : a_1[g];
         assign p_n[g] = (ins_ok && pos == '0) ? ld_prio : p_1[g];
      end else begin : g_rest
         assign a_n[g] = (!ins_ok || CNT_W'(g) < pos) ? a_1[g] :
                         (CNT_W'(g) == pos)            ? ld_addr : a_1[g-1];
         assign p_n[g] = (!ins_ok || CNT_W'(g) < pos) ? p_1[g] :
                         (CNT_W'(g) == pos)            ? ld_prio : p_1[g-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         ovf_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            a_q[i] <= '0;
            p_q[i] <= '0;
         end
      end else begin
         occ_q <= c_n;
         ovf_q <= ld_valid && !ins_ok;
         for (int i = 0; i < DEPTH; i++) begin
            a_q[i] <= a_n[i];
            p_q[i] <= p_n[i];
         end
      end
   end

   assign occ        = occ_q;
   assign head_valid = (occ_q != '0);
   assign head_addr  = a_q[0];
   assign hd_upd     = pop_ok || (ins_ok && pos == '0);
   assign nxt_valid  = (c_n != '0);
   assign nxt_addr   = a_n[0];
   assign ovf_pulse  = ovf_q;
endmodule

// File: rtl/thrq_fetch.sv
module thrq_fetch
   import thrq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int LINE_W   = 128,
   parameter int LINE_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hd_upd,
   input  logic              nxt_valid,
   input  logic [ADDR_W-1:0] nxt_addr,
   input  logic              head_valid,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              buf_valid,
   output logic [LINE_W-1:0] buf_line
);
   localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << LINE_OFS) - 1);

   fetch_st_t         st_q;
   logic              stale_q, bv_q;
   logic [ADDR_W-1:0] rq_q;
   logic [LINE_W-1:0] line_q;

   function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
      return a & ~OFS_MASK;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         stale_q <= 1'b0;
         bv_q    <= 1'b0;
         rq_q    <= '0;
         line_q  <= '0;
      end else begin
         if (hd_upd) bv_q <= 1'b0;
         unique case (st_q)
            FS_IDLE: begin
               if (hd_upd && nxt_valid) begin
                  st_q    <= FS_BUSY;
                  rq_q    <= line_of(nxt_addr);
                  stale_q <= 1'b0;
               end
            end
            FS_BUSY: begin
               if (mem_ack) begin
                  stale_q <= 1'b0;
                  if (hd_upd) begin
                     // head replaced on the acknowledge edge: drop, fetch the next head
                     st_q <= nxt_valid ? FS_BUSY : FS_IDLE;
                     rq_q <= line_of(nxt_addr);
                  end else if (stale_q) begin
                     st_q <= head_valid ? FS_BUSY : FS_IDLE;
                     rq_q <= line_of(head_addr);
                  end else begin
                     st_q   <= FS_IDLE;
                     bv_q   <= 1'b1;
                     line_q <= mem_data;
                  end
               end else if (hd_upd) begin
                  stale_q <= 1'b1;
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign mem_req   = (st_q == FS_BUSY);
   assign mem_addr  = rq_q;
   assign buf_valid = bv_q;
   assign buf_line  = line_q;
endmodule

// File: rtl/thrd_resume_q.sv
module thrd_resume_q #(
   parameter int ADDR_W = 16,
   parameter int PRIO_W = 3,
   parameter int DEPTH  = 4,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [PRIO_W-1:0] ld_prio,
   input  logic              pop,
   output logic              head_valid,
   output logic [ADDR_W-1:0] head_addr,
   output logic              buf_valid,
   output logic [LINE_W-1:0] buf_line,
   output logic              ovf_pulse,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_data
);
   localparam int CNT_W    = $clog2(DEPTH + 1);
   localparam int LINE_OFS = $clog2(LINE_W / 8);

   if (DEPTH < 2) begin : g_bad_depth
      $error("thrd_resume_q: DEPTH must be at least 2");
   end
   if ((LINE_W % 8 != 0) || ((1 << LINE_OFS) * 8 != LINE_W)) begin : g_bad_line
      $error("thrd_resume_q: LINE_W must be a power-of-two number of bytes");
   end
   if (LINE_OFS >= ADDR_W) begin : g_bad_addr
      $error("thrd_resume_q: ADDR_W too narrow for one line");
   end

   logic [CNT_W-1:0]  occ;
   logic              hd_upd, nxt_valid;
   logic [ADDR_W-1:0] nxt_addr;

   thrq_store #(
      .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_prio(ld_prio), .pop(pop),
      .occ(occ), .head_valid(head_valid), .head_addr(head_addr),
      .hd_upd(hd_upd), .nxt_valid(nxt_valid), .nxt_addr(nxt_addr),
      .ovf_pulse(ovf_pulse)
   );

   thrq_fetch #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .LINE_OFS(LINE_OFS)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .hd_upd(hd_upd), .nxt_valid(nxt_valid), .nxt_addr(nxt_addr),
      .head_valid(head_valid), .head_addr(head_addr),
      .mem_ack(mem_ack), .mem_data(mem_data),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .buf_valid(buf_valid), .buf_line(buf_line)
   );
endmodule

// File: rtl/thrq_chk.sv
module thrq_chk #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic              pop,
   input logic [CNT_W-1:0]  occ,
   input logic              head_valid,
   input logic [ADDR_W-1:0] head_addr,
   input logic              buf_valid,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic              ovf_pulse
);
   AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(ld_valid && !pop && occ == CNT_W'(DEPTH))); // R4
   AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !ld_valid && occ == '0) |=> (occ == '0 && !mem_req)); // R5
   AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !ld_valid && occ != '0) |=> occ == $past(occ) - CNT_W'(1)); // R8
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6
   AST_NEW_HEAD_NO_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !$stable(head_addr)) |-> !buf_valid); // R6
   AST_BUF_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      !head_valid |-> !buf_valid); // R7
   AST_FILL_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_valid) |-> $past(mem_req && mem_ack)); // R7
endmodule

bind thrd_resume_q thrq_chk #(
   .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .pop(pop), .occ(occ),
   .head_valid(head_valid), .head_addr(head_addr), .buf_valid(buf_valid),
   .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
   .ovf_pulse(ovf_pulse)
);

// File: tb/sim_thrd_resume_q.sv
`timescale 1ns/1ps
module sim_thrd_resume_q;
   localparam int AW = 16, PW = 3, DP = 4, LW = 128, LAT = 3;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          ld_valid = 1'b0, pop = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [PW-1:0] ld_prio = '0;
   logic          head_valid, buf_valid, ovf_pulse, mem_req;
   logic [AW-1:0] head_addr, mem_addr;
   logic [LW-1:0] buf_line;
   logic          mem_ack = 1'b0;
   logic [LW-1:0] mem_data = '0;

   int n_chk = 0, n_bad = 0, n_ack = 0, mcnt = 0;
   bit done = 0;
   logic [AW-1:0] m_addr[$];
   logic [PW-1:0] m_prio[$];
   logic [AW+LW-1:0] exp_q[$];
   logic prev_bv = 1'b0;

   always #2 clk = ~clk;

   thrd_resume_q u0 (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .ld_prio(ld_prio), .pop(pop), .head_valid(head_valid),
      .head_addr(head_addr), .buf_valid(buf_valid), .buf_line(buf_line),
      .ovf_pulse(ovf_pulse), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_data(mem_data)
   );

   function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
      return {a, ~a, a ^ 16'h5A5A, a + 16'h0101, a ^ 16'h3C3C, 16'hBEEF, a, ~a};
   endfunction
   function automatic logic [AW-1:0] aln(input logic [AW-1:0] a);
      return a & 16'hFFF0;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [LW-1:0] act,
                      input logic [LW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // memory model: acknowledges a held request after LAT cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         mcnt = 0; mem_ack = 1'b0;
      end else begin
         mem_ack = 1'b0;
         if (mem_req) begin
            if (mcnt == LAT) begin
               mem_ack = 1'b1; mem_data = pat(mem_addr); mcnt = 0; n_ack++;
            end else mcnt++;
         end else mcnt = 0;
      end
   end

   // monitor: scoreboard on pops, line/head consistency on each fill (R7, R8)
   always begin
      @(negedge clk); #1;
      if (rst_n) begin
         if (buf_valid && !prev_bv)
            chk(buf_line == pat(aln(head_addr)), "R7 fill", buf_line, pat(aln(head_addr)));
         if (pop && buf_valid) begin
            if (exp_q.size() == 0) chk(0, "R8 unexpected pop", {head_addr, buf_line}, '0);
            else begin
               logic [AW+LW-1:0] e;
               e = exp_q.pop_front();
               chk({head_addr, buf_line} == e, "R8 handover",
                   {head_addr, buf_line}, e);
            end
         end
      end
      prev_bv = buf_valid;
   end

   function automatic void m_ins(input logic [AW-1:0] a, input logic [PW-1:0] p);
      int k = 0;
      foreach (m_prio[i]) if (m_prio[i] <= p) k++;
      m_addr.insert(k, a); m_prio.insert(k, p);
   endfunction

   task automatic chk_head(input string rq);
      chk(head_valid == (m_addr.size() != 0), rq, head_valid, m_addr.size() != 0);
      if (m_addr.size() != 0) chk(head_addr == m_addr[0], rq, head_addr, m_addr[0]);
   endtask

   task automatic do_load(input logic [AW-1:0] a, input logic [PW-1:0] p);
      bit full = (m_addr.size() == DP);
      ld_valid = 1'b1; ld_addr = a; ld_prio = p;
      @(negedge clk);
      ld_valid = 1'b0;
      if (!full) m_ins(a, p);
      chk(ovf_pulse == full, "R4 ovf", ovf_pulse, full);
      chk_head("R2 head after load");
   endtask

   task automatic wait_buf();
      for (int i = 0; i < 100 && !buf_valid; i++) @(negedge clk);
      chk(buf_valid, "R7 line arrival", buf_valid, 1'b1);
   endtask

   task automatic do_pop(input bit with_ld, input logic [AW-1:0] a, input logic [PW-1:0] p);
      wait_buf();
      exp_q.push_back({m_addr[0], pat(aln(m_addr[0]))});
      pop = 1'b1;
      if (with_ld) begin ld_valid = 1'b1; ld_addr = a; ld_prio = p; end
      @(negedge clk);
      pop = 1'b0; ld_valid = 1'b0;
      void'(m_addr.pop_front()); void'(m_prio.pop_front());
      if (with_ld) begin
         m_ins(a, p);
         chk(ovf_pulse == 1'b0, "R10 no ovf", ovf_pulse, 1'b0);
      end
      chk_head("R3 order after pop");
      chk(buf_valid == 1'b0, "R6 buffer cleared", buf_valid, 1'b0);
      if (m_addr.size() != 0) begin
         chk(mem_req == 1'b1, "R6 refetch", mem_req, 1'b1);
         chk(mem_addr == aln(m_addr[0]), "R6 line addr", mem_addr, aln(m_addr[0]));
      end
   endtask

   initial begin
      int a0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk({head_valid, buf_valid, mem_req, ovf_pulse} == 4'b0, "R1 reset",
          {head_valid, buf_valid, mem_req, ovf_pulse}, 4'b0);
      // R5: pop on empty queue
      pop = 1'b1; @(negedge clk); pop = 1'b0;
      @(negedge clk);
      chk(head_valid == 1'b0, "R5 empty pop head", head_valid, 1'b0);
      chk(mem_req == 1'b0, "R5 empty pop no request", mem_req, 1'b0);
      // R9: head replaced while the first fetch is in flight
      a0 = n_ack;
      do_load(16'h1234, 3'd6);
      chk(mem_req && mem_addr == 16'h1230, "R6 first request", mem_addr, 16'h1230);
      do_load(16'h4568, 3'd2);
      wait_buf();
      chk(buf_line == pat(16'h4560), "R9 refetched line", buf_line, pat(16'h4560));
      chk(n_ack - a0 == 2, "R9 two acknowledges", n_ack - a0, 2);
      do_pop(0, '0, '0);
      do_pop(0, '0, '0);
      chk(!head_valid && !buf_valid, "R5 drained", {head_valid, buf_valid}, 2'b0);
      // R2/R3 ordering, R4 overflow, R10 combined pop and load
      do_load(16'h0100, 3'd3);
      do_load(16'h0200, 3'd1);
      do_load(16'h0300, 3'd3);
      do_load(16'h0400, 3'd0);
      do_load(16'h0500, 3'd0);
      chk(head_addr == 16'h0400, "R4 contents unchanged", head_addr, 16'h0400);
      @(negedge clk);
      chk(ovf_pulse == 1'b0, "R4 pulse one cycle", ovf_pulse, 1'b0);
      do_pop(1, 16'h0608, 3'd2);
      chk(head_addr == 16'h0200, "R10 head", head_addr, 16'h0200);
      repeat (4) do_pop(0, '0, '0);
      pop = 1'b1; @(negedge clk); pop = 1'b0;
      @(negedge clk);
      chk(!head_valid && !mem_req, "R5 pop after drain", {head_valid, mem_req}, 2'b0);
      chk(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule